// File: doc/BRIEF.md
# Pulse-Distance Frame Receiver

This block turns one stream of 12-bit samples from an optical front end into decoded 24-bit frames. Each sample arrives with a one-cycle enable. The sample is sliced against a fixed level. Its active bit is pushed into a sliding window, and the number of ones in that window is used to find the long header burst. After the header, the block measures the length of every inactive run between bursts and turns each run into one data bit. A run that is too short, or a burst that is too long, is treated as a disturbance and sends the block back to hunting for a header.

Once 24 bits have been gathered, the block splits the word into its fields and recomputes an 8-bit CRC over the lower two bytes. It then raises a one-cycle pulse that says either "good frame" or "CRC mismatch". To receive on several channels, place one instance per channel.

Top module: `pdist_frame_rx`

## Requirements
- R1: A sample counts as active when its value, read as unsigned, is greater than 2048: a value of 2048 is inactive and 2049 is active. With the INVERT parameter set to 1, this decision is flipped.
- R2: Clock cycles with sample_en low have no effect on decoding, whatever sample carries in those cycles.
- R3: A frame starts when at least 24 of the last 32 samples are active. The line format is a 32-sample active header, an 8-sample inactive gap, then 24 bits.
- R4: Each bit is an inactive run followed by an active burst. After the first bit, a run of 13 or more samples decodes as 1 and a run of 5 to 12 samples decodes as 0. For the first bit, the header gap is discounted, so an 8-sample run gives 0 and a 16-sample run gives 1.
- R5: An inactive run of 4 samples or fewer between bursts abandons the frame with no output pulse, and the block then accepts a new header.
- R6: A burst of 12 active samples is accepted. A burst of 13 or more abandons the frame with no output pulse.
- R7: Bits are gathered least significant first: the first bit received becomes bit 0 of the 24-bit word.
- R8: Word fields: type is bits 2:0, ID is bits 10:3, amount is bits 15:11, and the CRC is bits 23:16.
- R9: The CRC is CRC-8 with polynomial 0x07 and initial value 0. It runs over bits 7:0 and then bits 15:8, each byte most significant bit first. On a match, frame_valid pulses for one clock cycle and the type, ID and amount outputs take the new values.
- R10: On a mismatch, crc_error pulses for one clock cycle and the type, ID and amount outputs keep their previous values.
- R11: After reset, all outputs are 0.
- R12: Each frame gives at most one pulse, and frame_valid and crc_error are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_en | input | 1 | Marks the cycle in which sample is valid |
| sample | input | 12 | Unsigned sample value |
| frame_valid | output | 1 | One-cycle pulse: frame received with matching CRC |
| crc_error | output | 1 | One-cycle pulse: frame received with CRC mismatch |
| frame_type | output | 3 | Type field of the last good frame |
| frame_id | output | 8 | ID field of the last good frame |
| frame_amount | output | 5 | Amount field of the last good frame |

## Verification
A wrong bit-timer or bit-counter value cannot stay hidden. The first frame that passes through the fault gives a wrong field, a false crc_error, or no pulse at all, and this shows at most one clock after the final burst begins. A decoder that fails to return to header hunting after an abandoned frame loses the next frame entirely, so every abort case is followed by a clean frame that must decode. Bursts and runs placed exactly on each threshold, and junk values driven while sample_en is low, expose off-by-one timing and enable-gating faults within a single frame.

// File: rtl/pdrx_pkg.sv
package pdrx_pkg;

   localparam int TYPE_W = 3;
   localparam int ID_W   = 8;
   localparam int AMT_W  = 5;
   localparam int CRC_W  = 8;
   localparam int DATA_W = TYPE_W + ID_W + AMT_W;
   localparam int FRAME_W = DATA_W + CRC_W;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SYNC,
      ST_GAP,
      ST_SPACE,
      ST_MARK,
      ST_CHECK
   } rx_state_e;

   // CRC-8, zero seed; low byte first, each byte MSB first
   function automatic logic [CRC_W-1:0] crc8_calc(input logic [DATA_W-1:0] d,
                                                  input logic [CRC_W-1:0] poly);
      logic [CRC_W-1:0] c;
      c = '0;
      for (int b = 0; b < DATA_W / 8; b++) begin
         c = c ^ d[8*b +: 8];
         for (int k = 0; k < 8; k++) begin
            if (c[CRC_W-1]) c = (c << 1) ^ poly;
            else            c = c << 1;
         end
      end
      return c;
   endfunction

endpackage

// File: rtl/pdrx_slicer.sv
module pdrx_slicer #(
   parameter int SAMPLE_W = 12,
   parameter int THRESH   = 2048,
   parameter int INVERT   = 0,
   parameter int WIN_LEN  = 32,
   localparam int EN_W    = $clog2(WIN_LEN + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sample_en,
   input  logic [SAMPLE_W-1:0] sample,
   output logic                active,
   output logic [EN_W-1:0]     energy
);

   logic [WIN_LEN-1:0] window_q;
   logic [WIN_LEN-1:0] window_d;
   logic               above;

   assign above = (sample > SAMPLE_W'(THRESH));

   generate
      if (INVERT != 0) begin : g_inv
         assign active = ~above;
      end else begin : g_pass
         assign active = above;
      end
      if (WIN_LEN < 2) begin : g_bad_win
         $error("pdrx_slicer: WIN_LEN must be at least 2");
      end
   endgenerate

   assign window_d = {window_q[WIN_LEN-2:0], active};
   assign energy   = EN_W'($countones(window_d));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         window_q <= '0;
      else if (sample_en) window_q <= window_d;
   end

endmodule

// File: rtl/pdrx_bit_fsm.sv
module pdrx_bit_fsm
   import pdrx_pkg::*;
#(
   parameter int EN_W      = 6,
   parameter int HDR_MIN   = 24,
   parameter int SYNC_WAIT = 10,
   parameter int HDR_GAP   = 8,
   parameter int ZERO_MIN  = 4,
   parameter int ONE_MIN   = 12,
   parameter int MARK_MAX  = 12,
   parameter int TMR_W     = 8,
   localparam int CNT_W    = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sample_en,
   input  logic               active,
   input  logic [EN_W-1:0]    energy,
   output logic               frame_done,
   output logic [FRAME_W-1:0] frame_word
);

   rx_state_e          state;
   logic [TMR_W-1:0]   timer;
   logic [CNT_W-1:0]   bit_cnt;
   logic [FRAME_W-1:0] acc;
   logic [TMR_W-1:0]   eff;

   generate
      if (ZERO_MIN >= ONE_MIN) begin : g_bad_thr
         $error("pdrx_bit_fsm: ZERO_MIN must be below ONE_MIN");
      end
      if (MARK_MAX >= (1 << TMR_W) - 1 || ONE_MIN + HDR_GAP >= (1 << TMR_W) - 1) begin : g_bad_tmr
         $error("pdrx_bit_fsm: TMR_W too narrow");
      end
   endgenerate

   // the first run also spans the header gap; discount it
   always_comb begin
      if (bit_cnt == '0)
         eff = (timer >= TMR_W'(HDR_GAP)) ? timer - TMR_W'(HDR_GAP) : '0;
      else
         eff = timer;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         timer   <= '0;
         bit_cnt <= '0;
         acc     <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (sample_en && energy >= EN_W'(HDR_MIN)) begin
                  state <= ST_SYNC;
                  timer <= '0;
               end
            end
            ST_SYNC: begin
               if (sample_en) begin
                  timer <= timer + 1'b1;
                  if (timer + 1'b1 >= TMR_W'(SYNC_WAIT)) state <= ST_GAP;
               end
            end
            ST_GAP: begin
               if (sample_en && !active) begin
                  state   <= ST_SPACE;
                  timer   <= '0;
                  bit_cnt <= '0;
                  acc     <= '0;
               end
            end
            ST_SPACE: begin
               if (sample_en) begin
                  if (active) begin
                     if (eff >= TMR_W'(ZERO_MIN)) begin
                        acc     <= {(eff >= TMR_W'(ONE_MIN)), acc[FRAME_W-1:1]};
                        bit_cnt <= bit_cnt + 1'b1;
                        state   <= (bit_cnt == CNT_W'(FRAME_W - 1)) ? ST_CHECK : ST_MARK;
                        timer   <= TMR_W'(1);
                     end else begin
                        state <= ST_IDLE;
                        timer <= '0;
                     end
                  end else if (timer != '1) begin
                     timer <= timer + 1'b1;
                  end
               end
            end
            ST_MARK: begin
               if (sample_en) begin
                  if (!active) begin
                     state <= ST_SPACE;
                     timer <= '0;
                  end else if (timer >= TMR_W'(MARK_MAX)) begin
                     state <= ST_IDLE;
                     timer <= '0;
                  end else begin
                     timer <= timer + 1'b1;
                  end
               end
            end
            ST_CHECK: begin
               state <= ST_IDLE;
               timer <= '0;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign frame_done = (state == ST_CHECK);
   assign frame_word = acc;

   // R3
   hdr_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_IDLE) && ($past(state) == ST_IDLE)
      |-> $past(sample_en) && ($past(energy) >= EN_W'(HDR_MIN)));

   // R2
   bit_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_cnt > $past(bit_cnt)) |-> $past(sample_en) && $past(active));

endmodule

// File: rtl/pdrx_crc_check.sv
module pdrx_crc_check
   import pdrx_pkg::*;
#(
   parameter logic [CRC_W-1:0] CRC_POLY = 8'h07
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_done,
   input  logic [FRAME_W-1:0] frame_word,
   output logic               frame_valid,
   output logic               crc_error,
   output logic [TYPE_W-1:0]  frame_type,
   output logic [ID_W-1:0]    frame_id,
   output logic [AMT_W-1:0]   frame_amount
);

   logic [CRC_W-1:0] crc_calc;
   logic             crc_ok;

   assign crc_calc = crc8_calc(frame_word[DATA_W-1:0], CRC_POLY);
   assign crc_ok   = (crc_calc == frame_word[FRAME_W-1:DATA_W]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_valid  <= 1'b0;
         crc_error    <= 1'b0;
         frame_type   <= '0;
         frame_id     <= '0;
         frame_amount <= '0;
      end else begin
         frame_valid <= frame_done && crc_ok;
         crc_error   <= frame_done && !crc_ok;
         if (frame_done && crc_ok) begin
            frame_type   <= frame_word[TYPE_W-1:0];
            frame_id     <= frame_word[TYPE_W +: ID_W];
            frame_amount <= frame_word[TYPE_W+ID_W +: AMT_W];
         end
      end
   end

   // R12
   one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({frame_valid, crc_error}));

   // R9
   valid_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid || crc_error) |-> $past(frame_done));

   // R10
   field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid |-> $stable(frame_id) && $stable(frame_type) && $stable(frame_amount));

endmodule

// File: rtl/pdist_frame_rx.sv
module pdist_frame_rx
   import pdrx_pkg::*;
#(
   parameter int SAMPLE_W  = 12,
   parameter int THRESH    = 2048,
   parameter int INVERT    = 0,
   parameter int WIN_LEN   = 32,
   parameter int HDR_MIN   = 24,
   parameter int SYNC_WAIT = 10,
   parameter int HDR_GAP   = 8,
   parameter int ZERO_MIN  = 4,
   parameter int ONE_MIN   = 12,
   parameter int MARK_MAX  = 12,
   parameter int TMR_W     = 8,
   parameter logic [CRC_W-1:0] CRC_POLY = 8'h07,
   localparam int EN_W     = $clog2(WIN_LEN + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sample_en,
   input  logic [SAMPLE_W-1:0] sample,
   output logic                frame_valid,
   output logic                crc_error,
   output logic [TYPE_W-1:0]   frame_type,
   output logic [ID_W-1:0]     frame_id,
   output logic [AMT_W-1:0]    frame_amount
);

   generate
      if (HDR_MIN > WIN_LEN || HDR_MIN < 1) begin : g_bad_hdr
         $error("pdist_frame_rx: HDR_MIN must lie in 1..WIN_LEN");
      end
      if (THRESH >= (1 << SAMPLE_W)) begin : g_bad_lvl
         $error("pdist_frame_rx: THRESH exceeds sample range");
      end
   endgenerate

   logic               act;
   logic [EN_W-1:0]    energy;
   logic               done;
   logic [FRAME_W-1:0] word;

   pdrx_slicer #(
      .SAMPLE_W (SAMPLE_W),
      .THRESH   (THRESH),
      .INVERT   (INVERT),
      .WIN_LEN  (WIN_LEN)
   ) slicer_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sample_en (sample_en),
      .sample    (sample),
      .active    (act),
      .energy    (energy)
   );

   pdrx_bit_fsm #(
      .EN_W      (EN_W),
      .HDR_MIN   (HDR_MIN),
      .SYNC_WAIT (SYNC_WAIT),
      .HDR_GAP   (HDR_GAP),
      .ZERO_MIN  (ZERO_MIN),
      .ONE_MIN   (ONE_MIN),
      .MARK_MAX  (MARK_MAX),
      .TMR_W     (TMR_W)
   ) fsm_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .sample_en  (sample_en),
      .active     (act),
      .energy     (energy),
      .frame_done (done),
      .frame_word (word)
   );

   pdrx_crc_check #(
      .CRC_POLY (CRC_POLY)
   ) crc_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_done   (done),
      .frame_word   (word),
      .frame_valid  (frame_valid),
      .crc_error    (crc_error),
      .frame_type   (frame_type),
      .frame_id     (frame_id),
      .frame_amount (frame_amount)
   );

endmodule

// File: tb/pdist_frame_rx_tb_top.sv
module pdist_frame_rx_tb_top;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        sample_en;
   logic [11:0] sample;
   logic [11:0] sample_n;
   logic        frame_valid, crc_error;
   logic [2:0]  frame_type;
   logic [7:0]  frame_id;
   logic [4:0]  frame_amount;
   logic        v_inv, e_inv;
   logic [2:0]  t_inv;
   logic [7:0]  id_inv;
   logic [4:0]  am_inv;

   always #5 clk = ~clk;

   pdist_frame_rx dut_i (
      .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .sample(sample),
      .frame_valid(frame_valid), .crc_error(crc_error),
      .frame_type(frame_type), .frame_id(frame_id), .frame_amount(frame_amount));

   pdist_frame_rx #(.INVERT(1)) dut_inv_i (
      .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .sample(sample_n),
      .frame_valid(v_inv), .crc_error(e_inv),
      .frame_type(t_inv), .frame_id(id_inv), .frame_amount(am_inv));

   typedef struct packed {
      logic       err;
      logic [2:0] t;
      logic [7:0] id;
      logic [4:0] am;
   } exp_t;

   exp_t        exp_q[$];
   int          n_chk = 0;
   int          n_bad = 0;
   int          n_pulse = 0;
   int          n_tick = 0;
   int          stretch = 0;
   bit          done = 1'b0;
   logic [11:0] act_v = 12'd4000;
   logic [11:0] inact_v = 12'd100;
   logic [2:0]  m_t = '0;
   logic [7:0]  m_id = '0;
   logic [4:0]  m_am = '0;

   task automatic check(input bit ok, input string tag, input string detail);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: %s", tag, detail);
      end
   endtask

   function automatic logic [7:0] ref_crc(input logic [15:0] d);
      logic [7:0] c;
      logic       fb;
      c = 8'h00;
      for (int by = 0; by < 2; by++) begin
         for (int bi = 7; bi >= 0; bi--) begin
            fb = c[7] ^ d[8*by + bi];
            c  = {c[6:0], 1'b0};
            if (fb) c = c ^ 8'h07;
         end
      end
      return c;
   endfunction

   // R8: type [2:0], id [10:3], amount [15:11], crc [23:16]
   function automatic logic [23:0] mk_word(input logic [2:0] t, input logic [7:0] id,
                                           input logic [4:0] am);
      logic [15:0] d;
      d = {am, id, t};
      return {ref_crc(d), d};
   endfunction

   task automatic expect_word(input logic [23:0] w);
      exp_t e;
      if (ref_crc(w[15:0]) == w[23:16]) begin
         m_t = w[2:0]; m_id = w[10:3]; m_am = w[15:11];
         e = '{err: 1'b0, t: m_t, id: m_id, am: m_am};
      end else begin
         e = '{err: 1'b1, t: m_t, id: m_id, am: m_am};
      end
      exp_q.push_back(e);
   endtask

   // R2: cycles with sample_en low carry the opposite level
   task automatic tick(input bit lvl);
      @(negedge clk);
      sample_en = 1'b1;
      sample    = lvl ? act_v : inact_v;
      sample_n  = lvl ? inact_v : act_v;
      @(negedge clk);
      sample_en = 1'b0;
      sample    = lvl ? inact_v : act_v;
      sample_n  = lvl ? act_v : inact_v;
      n_tick++;
      if (n_tick % 3 == 0) @(negedge clk);
      repeat (stretch) @(negedge clk);
   endtask

   task automatic run(input bit lvl, input int n);
      repeat (n) tick(lvl);
   endtask

   // idx selects one bit whose run (sp) or burst (mk) length is overridden
   task automatic send(input logic [23:0] w, input int idx, input int sp, input int mk);
      run(1'b1, 32);
      run(1'b0, 8);
      for (int i = 0; i < 24; i++) begin
         run(1'b0, (i == idx && sp > 0) ? sp : (w[i] ? 16 : 8));
         run(1'b1, (i == idx && mk > 0) ? mk : 8);
      end
      run(1'b0, 40);
   endtask

   task automatic good_frame(input logic [23:0] w, input int idx, input int sp,
                             input int mk, input string tag);
      expect_word(w);
      send(w, idx, sp, mk);
      check(exp_q.size() == 0, tag,
            $sformatf("pending results actual=%0d expected=0", exp_q.size()));
   endtask

   task automatic no_frame(input logic [23:0] w, input int idx, input int sp,
                           input int mk, input string tag);
      int p0;
      p0 = n_pulse;
      send(w, idx, sp, mk);
      check(n_pulse == p0, tag,
            $sformatf("pulses actual=%0d expected=0", n_pulse - p0));
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      exp_t e;
      if (rst_n && (frame_valid || crc_error || v_inv || e_inv)) begin
         n_pulse++;
         // R1: inverted slicing on mirrored samples gives identical results
         check({v_inv, e_inv, t_inv, id_inv, am_inv} ==
               {frame_valid, crc_error, frame_type, frame_id, frame_amount}, "R1",
               $sformatf("inverted dut actual=%0b%0b/%0h/%0h/%0h expected=%0b%0b/%0h/%0h/%0h",
                         v_inv, e_inv, t_inv, id_inv, am_inv,
                         frame_valid, crc_error, frame_type, frame_id, frame_amount));
         if (exp_q.size() == 0) begin
            check(1'b0, "R12", $sformatf("unexpected pulse actual=%0b%0b expected=none",
                                         frame_valid, crc_error));
         end else begin
            e = exp_q.pop_front();
            check(frame_valid == !e.err && crc_error == e.err, e.err ? "R10" : "R9",
                  $sformatf("valid/err actual=%0b%0b expected=%0b%0b",
                            frame_valid, crc_error, !e.err, e.err));
            check(frame_type == e.t && frame_id == e.id && frame_amount == e.am,
                  e.err ? "R10" : "R8",
                  $sformatf("fields actual=%0h/%0h/%0h expected=%0h/%0h/%0h",
                            frame_type, frame_id, frame_amount, e.t, e.id, e.am));
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog R3: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; sample_en = 1'b0; sample = '0; sample_n = '0;
      repeat (4) @(negedge clk);
      // R11
      check({frame_valid, crc_error, frame_type, frame_id, frame_amount} == '0, "R11",
            $sformatf("reset outputs actual=%0b%0b/%0h/%0h/%0h expected=0",
                      frame_valid, crc_error, frame_type, frame_id, frame_amount));
      rst_n = 1'b1;
      run(1'b0, 40);

      // R3 R7: nominal frame
      good_frame(mk_word(3'd1, 8'd42, 5'd23), -1, 0, 0, "R3");
      // R9: all-zero payload
      good_frame(mk_word(3'd0, 8'd0, 5'd0), -1, 0, 0, "R9");
      // R4: all ones payload, first bit is 1 with 16-sample run
      good_frame(mk_word(3'd7, 8'hFF, 5'd31), -1, 0, 0, "R4");
      // R7: asymmetric pattern pins bit order
      good_frame(mk_word(3'd6, 8'h01, 5'd16), -1, 0, 0, "R7");
      // R1: threshold boundary 2049 active, 2048 inactive
      act_v = 12'd2049; inact_v = 12'd2048;
      good_frame(mk_word(3'd5, 8'hA5, 5'd10), -1, 0, 0, "R1");
      act_v = 12'd4000; inact_v = 12'd100;
      // R10: corrupted CRC byte, fields hold
      good_frame(mk_word(3'd2, 8'd17, 5'd9) ^ 24'h010000, -1, 0, 0, "R10");
      check(frame_id == 8'hA5 && frame_type == 3'd5, "R10",
            $sformatf("held id/type actual=%0h/%0h expected=a5/5", frame_id, frame_type));
      // R4: run boundaries on bit 5
      good_frame(mk_word(3'd0, 8'h04, 5'd0), 5, 13, 0, "R4");
      good_frame(mk_word(3'd0, 8'h00, 5'd3), 5, 12, 0, "R4");
      good_frame(mk_word(3'd3, 8'h10, 5'd1), 5, 5, 0, "R4");
      // R5: run of 4 abandons, then a clean frame decodes
      no_frame(mk_word(3'd1, 8'd1, 5'd1), 5, 4, 0, "R5");
      good_frame(mk_word(3'd4, 8'h3C, 5'd7), -1, 0, 0, "R5");
      // R6: burst of 12 kept, 13 aborts
      good_frame(mk_word(3'd2, 8'h81, 5'd2), 5, 0, 12, "R6");
      no_frame(mk_word(3'd2, 8'h81, 5'd2), 5, 0, 13, "R6");
      good_frame(mk_word(3'd7, 8'h55, 5'd21), -1, 0, 0, "R6");
      // R2: long enable-low stretches between samples
      stretch = 4;
      good_frame(mk_word(3'd1, 8'hC3, 5'd12), -1, 0, 0, "R2");
      stretch = 0;

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule